// File: doc/BRIEF.md
# Watchdog Timer with Start-Up Grace Window

This block supervises a host processor that must show it is alive by toggling a kick line. Normal supervision does not begin at once. A grace window comes first, so the host can finish booting without being faulted. The host closes the window early with its first kick. If the window runs out with no kick, the block raises a fault. The grace window opens after power-on reset, after a reset event and at the end of every fault pulse. Turning the watchdog on with its enable input skips the grace window, and monitoring starts straight away.

All time intervals are build-time parameters counted in clock cycles. `BOOT_TICKS` sets the grace length, and a value of 0 means no grace window. `TMO_TICKS` sets the monitoring timeout and `FLT_TICKS` sets the length of the fault pulse. `RST_ONLY` selects a build with only a reset output: in that build the fault pulse appears on `rst_o` and `fault_o` stays low.

The controller is a four-state machine:

- `WD_IDLE`: the enable input is low.
- `WD_BOOT`: the grace window is running.
- `WD_MON`: the timeout is being monitored.
- `WD_FAULT`: the fault pulse is being driven.

The named transitions are:

- enable-off, from any state to `WD_IDLE`.
- enable-on, from `WD_IDLE` to `WD_MON`.
- reset-event, from any enabled state to the boot-entry state.
- boot-kick, from `WD_BOOT` to `WD_MON`.
- boot-expire, from `WD_BOOT` to `WD_FAULT`.
- mon-kick, which stays in `WD_MON` and restarts the count.
- mon-timeout, from `WD_MON` to `WD_FAULT`.
- fault-done, from `WD_FAULT` to the boot-entry state.

The boot-entry state is `WD_BOOT`, or `WD_MON` when `BOOT_TICKS` is 0. Power-on reset puts the machine in the boot-entry state.

Top module: `wdg_boot_guard`

## Requirements
- R1: When power-on reset is released with the enable input high, the block enters the grace window. Both outputs are low while reset is held.
- R2: While the grace window runs, neither output is asserted, even though kicks are watched.
- R3: If no kick arrives, the fault output rises exactly `BOOT_TICKS` cycles after the grace window opens.
- R4: A kick is either edge of `kick_i`. It is passed through a two-flop synchronizer and acts on the third rising clock edge after the input changes. A kick during the grace window ends the window, and the timeout is then counted from that point.
- R5: In monitoring, each kick restarts the count. After `TMO_TICKS` cycles with no kick, the fault output is asserted.
- R6: A one-cycle high on `rst_evt_i` restarts the grace window from its beginning, so the next fault comes `BOOT_TICKS` cycles later and not at the pending monitoring timeout.
- R7: While `en_i` is low, the block is idle, both outputs are low and the counts are cleared. This holds even if a fault pulse was running. Raising `en_i` starts monitoring directly, with no grace window.
- R8: The fault pulse lasts exactly `FLT_TICKS` cycles. After it, the grace window is entered again.
- R9: With `BOOT_TICKS` = 0, the boot-entry state is monitoring.
- R10: With `RST_ONLY` = 1, the fault pulse appears on `rst_o` and `fault_o` stays low. With `RST_ONLY` = 0, the pulse appears on `fault_o` and `rst_o` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| kick_i | input | 1 | Host kick line, asynchronous, either edge counts |
| en_i | input | 1 | Watchdog enable, synchronous |
| rst_evt_i | input | 1 | Reset event, synchronous, active high |
| fault_o | output | 1 | Watchdog fault pulse (low in the reset-only build) |
| rst_o | output | 1 | Reset output carrying the fault pulse in the reset-only build |

## Verification
The hardest case to reach is a fault that did not happen because the grace window was re-armed or skipped. From the ports, that looks the same as a block that is simply slow. The stimulus places each event so that the competing deadlines fall on different cycles, and it checks the output on both sides of each deadline:

- A reset event is pulsed shortly after a monitoring kick. The fault must be absent at the monitoring deadline and present at the later grace deadline.
- Enable is dropped in the middle of a fault pulse. When enable returns, the fault must appear at the monitoring deadline and not at the grace deadline.

Kicks alternate polarity, so both rising and falling edges are exercised.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
    typedef enum logic [1:0] {
        WD_IDLE  = 2'd0,
        WD_BOOT  = 2'd1,
        WD_MON   = 2'd2,
        WD_FAULT = 2'd3
    } wd_state_t;
endpackage

// File: rtl/wdg_kick_sync.sv
module wdg_kick_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    output logic edge_o
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
            last_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], kick_i};
            last_q <= sync_q[STAGES-1];
        end
    end

    // Either polarity of transition counts as a kick.
    assign edge_o = sync_q[STAGES-1] ^ last_q;
endmodule

// File: rtl/wdg_tick_cnt.sv
module wdg_tick_cnt #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (inc)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/wdg_boot_guard.sv
module wdg_boot_guard
    import wdg_pkg::*;
#(
    parameter int BOOT_TICKS = 1_000_000_000,
    parameter int TMO_TICKS  = 1_000_000,
    parameter int FLT_TICKS  = 1_000,
    parameter bit RST_ONLY   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick_i,
    input  logic en_i,
    input  logic rst_evt_i,
    output logic fault_o,
    output logic rst_o
);
    localparam int MAX_A = (BOOT_TICKS > TMO_TICKS) ? BOOT_TICKS : TMO_TICKS;
    localparam int MAX_T = (MAX_A > FLT_TICKS) ? MAX_A : FLT_TICKS;
    localparam int CW    = $clog2(MAX_T + 1);
    localparam logic [CW-1:0] BOOT_LAST = CW'((BOOT_TICKS > 0) ? BOOT_TICKS - 1 : 0);
    localparam logic [CW-1:0] TMO_LAST  = CW'((TMO_TICKS  > 0) ? TMO_TICKS  - 1 : 0);
    localparam logic [CW-1:0] FLT_LAST  = CW'((FLT_TICKS  > 0) ? FLT_TICKS  - 1 : 0);
    localparam wd_state_t BOOT_ENTRY = (BOOT_TICKS == 0) ? WD_MON : WD_BOOT;

    wd_state_t      state, nxt;
    logic           kick_ev;
    logic           cnt_clr, cnt_inc;
    logic [CW-1:0]  cnt;

    wdg_kick_sync #(.STAGES(2)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .kick_i (kick_i),
        .edge_o (kick_ev)
    );

    wdg_tick_cnt #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .cnt   (cnt)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= BOOT_ENTRY;
        else
            state <= nxt;
    end

    // Next state and counter control
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (!en_i) begin
            nxt     = WD_IDLE;      // enable-off
            cnt_clr = 1'b1;
        end else if (rst_evt_i) begin
            nxt     = BOOT_ENTRY;   // reset-event
            cnt_clr = 1'b1;
        end else begin
            unique case (state)
                WD_IDLE: begin
                    nxt     = WD_MON;   // enable-on, no grace window
                    cnt_clr = 1'b1;
                end
                WD_BOOT: begin
                    if (kick_ev) begin
                        nxt     = WD_MON;   // boot-kick
                        cnt_clr = 1'b1;
                    end else if (cnt == BOOT_LAST) begin
                        nxt     = WD_FAULT; // boot-expire
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                WD_MON: begin
                    if (kick_ev) begin
                        cnt_clr = 1'b1;     // mon-kick
                    end else if (cnt == TMO_LAST) begin
                        nxt     = WD_FAULT; // mon-timeout
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                WD_FAULT: begin
                    if (cnt == FLT_LAST) begin
                        nxt     = BOOT_ENTRY; // fault-done
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            endcase
        end
    end

    // Outputs decoded from the state register
    always_comb begin
        fault_o = 1'b0;
        rst_o   = 1'b0;
        if (state == WD_FAULT) begin
            if (RST_ONLY)
                rst_o = 1'b1;
            else
                fault_o = 1'b1;
        end
    end
endmodule

// File: rtl/wdg_boot_guard_chk.sv
module wdg_boot_guard_chk
    import wdg_pkg::*;
#(
    parameter int BOOT_TICKS = 1
) (
    input logic      clk,
    input logic      rst_n,
    input logic      en_i,
    input logic      rst_evt_i,
    input logic      kick_ev,
    input wd_state_t st,
    input logic      fault_o,
    input logic      rst_o
);
    localparam wd_state_t ENTRY = (BOOT_TICKS == 0) ? WD_MON : WD_BOOT;

    assert_boot_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_BOOT) |-> (!fault_o && !rst_o));

    assert_boot_kick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_BOOT && kick_ev && en_i && !rst_evt_i) |=> (st == WD_MON));

    assert_mon_kick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_MON && kick_ev && en_i && !rst_evt_i) |=> (st == WD_MON));

    assert_fault_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st == WD_FAULT) |-> ($past(st) == WD_BOOT || $past(st) == WD_MON));

    assert_evt_rearm_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && en_i) |=> (st == ENTRY));

    assert_disable_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!en_i) |=> (st == WD_IDLE && !fault_o && !rst_o));

    assert_enable_direct_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_IDLE && en_i && !rst_evt_i) |=> (st == WD_MON));

    assert_single_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fault_o && rst_o));

    assert_fault_visible_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_FAULT) |-> (fault_o || rst_o));
endmodule

bind wdg_boot_guard wdg_boot_guard_chk #(.BOOT_TICKS(BOOT_TICKS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en_i      (en_i),
    .rst_evt_i (rst_evt_i),
    .kick_ev   (kick_ev),
    .st        (state),
    .fault_o   (fault_o),
    .rst_o     (rst_o)
);

// File: tb/sim_wdg_boot_guard.sv
module sim_wdg_boot_guard;
    localparam int B = 20;
    localparam int T = 12;
    localparam int F = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic kick = 1'b0;
    logic en = 1'b1;
    logic evt = 1'b0;
    logic f0, r0, f1, r1;

    int cyc = 0;
    int checks = 0;
    int fails = 0;
    int base = 0;

    typedef struct {
        int    at;
        bit    dev;
        bit    ef;
        bit    er;
        string tag;
    } exp_t;
    exp_t sbq[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Main build: grace window, fault on fault_o
    wdg_boot_guard #(.BOOT_TICKS(B), .TMO_TICKS(T), .FLT_TICKS(F), .RST_ONLY(1'b0)) u0 (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .en_i(en), .rst_evt_i(evt),
        .fault_o(f0), .rst_o(r0));

    // Reset-only build with no grace window (R9, R10)
    wdg_boot_guard #(.BOOT_TICKS(0), .TMO_TICKS(T), .FLT_TICKS(F), .RST_ONLY(1'b1)) u1 (
        .clk(clk), .rst_n(rst_n), .kick_i(kick), .en_i(en), .rst_evt_i(evt),
        .fault_o(f1), .rst_o(r1));

    task automatic push(int rel, bit dev, bit ef, bit er, string tag);
        exp_t e;
        e.at = base + rel; e.dev = dev; e.ef = ef; e.er = er; e.tag = tag;
        sbq.push_back(e);
    endtask

    task automatic upto(int rel);
        while (cyc < base + rel) @(negedge clk);
    endtask

    // Monitor: pops expected items on their cycle and compares.
    always @(negedge clk) begin
        while (sbq.size() > 0 && sbq[0].at <= cyc) begin
            exp_t e;
            bit af, ar;
            e = sbq.pop_front();
            af = e.dev ? f1 : f0;
            ar = e.dev ? r1 : r0;
            checks++;
            if (e.at != cyc || af != e.ef || ar != e.er) begin
                fails++;
                $display("FAIL %s dev=u%0d cyc=%0d: fault=%0b rst=%0b expected fault=%0b rst=%0b",
                         e.tag, e.dev, e.at - base, af, ar, e.ef, e.er);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: outputs low while reset held
        checks++;
        if (f0 || r0 || f1 || r1) begin
            fails++;
            $display("FAIL R1 reset: outputs %0b%0b%0b%0b expected 0000", f0, r0, f1, r1);
        end
        rst_n = 1'b1;
        base = cyc;
        // R9 R10: u1 monitors at once, pulse on rst_o; R1 R2 R3 R8 on u0
        push(T - 1,         1, 0, 0, "R9");
        push(T,             1, 0, 1, "R10");
        push(B - 1,         0, 0, 0, "R1 R2");
        push(B,             0, 1, 0, "R3");
        push(B + F - 1,     0, 1, 0, "R8");
        push(B + F,         0, 0, 0, "R8");
        push(T + F + T - 1, 1, 0, 0, "R9");
        push(T + F + T,     1, 0, 1, "R10");
        // Second grace window opened at 24: kick at 26 ends it (R4)
        upto(26); kick = 1'b1;
        push(40, 0, 0, 0, "R4");
        push(41, 0, 1, 0, "R4");
        // Fault 41..44, grace from 45; kick at 46 then every 8 (R5)
        upto(46); kick = 1'b0;
        upto(54); kick = 1'b1;
        upto(62); kick = 1'b0;
        upto(70); kick = 1'b1;
        push(72, 0, 0, 0, "R5");
        push(84, 0, 0, 0, "R5");
        push(85, 0, 1, 0, "R5");
        push(89, 0, 0, 0, "R8");
        // Grace from 89, kick at 90 -> monitoring at 93; reset event at 96 (R6)
        upto(90); kick = 1'b0;
        upto(96); evt = 1'b1;
        upto(97); evt = 1'b0;
        push(105, 0, 0, 0, "R6");
        push(116, 0, 0, 0, "R6");
        push(117, 0, 1, 0, "R6");
        // Drop enable inside the fault pulse, restore later (R7)
        upto(118); en = 1'b0;
        push(119, 0, 0, 0, "R7");
        push(130, 0, 0, 0, "R7");
        upto(132); en = 1'b1;
        push(144, 0, 0, 0, "R7");
        push(145, 0, 1, 0, "R7");
        upto(150);
        while (sbq.size() > 0) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule